// File: doc/BRIEF.md
# UART Automatic Modem-Line Flow Control

This block performs automatic flow control for a single UART channel. On the receive side it compares the receive FIFO fill count against two marks. It drives an active-low request output that tells the remote end to pause when the FIFO gets full, and to resume once the FIFO has drained. The marks come from the programmed trigger level. They are widened by a 4-bit hysteresis code when the hysteresis trigger table is selected. Otherwise the next trigger level above the current one serves as the pause mark.

On the transmit side the block synchronizes an active-low clear input through two flops. It withholds the transmitter's permission to start a new character while that input is high. A character already being shifted out is not affected, because the serializer samples the permission only at a character boundary. One select bit chooses which modem pins are used: the RTS/CTS pair or the DTR/DSR pair. The output of the unused pair follows its software-written bit.

Top module: `uart_autoflow`

## Requirements
- R1: The hysteresis code maps to a character count: 0→0, 1→4, 2→6, 3→8, 4→8, 5→16, 6→24, 7→32, 8→40, 9→44, 10→48, 11→52, 12→12, 13→20, 14→28, 15→36.
- R2: With `tbl_sel` = 2'b11 and a nonzero code of value H, the driven request output goes high one clock after the count is at or above trigger + H.
- R3: In the same mode the request output goes low one clock after the count is at or below trigger − H, clamped at 0.
- R4: While the count lies strictly between the two marks, the request output keeps its previous level.
- R5: If `tbl_sel` is not 2'b11, or the code is 0, the pause mark is `next_trig`. The resume condition is then count < `rx_trig`; when `rx_trig` is 0, it is count = 0.
- R6: While `auto_rts_en` is 0, the driven request output equals the inverse of its software bit, combinationally, and the pause state is cleared. Re-enabling starts from the low (go) level.
- R7: With `pin_sel` = 0, RTS#/CTS# are used and `dtr_n` = ~`sw_dtr`. With `pin_sel` = 1, DTR#/DSR# are used and `rts_n` = ~`sw_rts`.
- R8: With `auto_cts_en` = 1, `tx_go` equals the inverse of the monitored input as it was two clocks earlier. With `auto_cts_en` = 0, `tx_go` is 1 at once, whatever the pins do.
- R9: During and after reset, the pause state is clear and both synchronizer flops hold 1. With automatic CTS enabled, `tx_go` therefore stays 0 until the second clock after reset is released.
- R10: When the pause and resume conditions both hold at once, pause wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Programmed receive trigger level |
| next_trig | input | CNT_W | Next trigger level above `rx_trig` |
| tbl_sel | input | 2 | Trigger table select; 2'b11 enables hysteresis |
| hyst_code | input | 4 | Hysteresis select code |
| auto_rts_en | input | 1 | Enable automatic request output |
| auto_cts_en | input | 1 | Enable automatic transmit gating |
| pin_sel | input | 1 | 0: RTS#/CTS#, 1: DTR#/DSR# |
| sw_rts | input | 1 | Software RTS bit (1 drives pin low) |
| sw_dtr | input | 1 | Software DTR bit (1 drives pin low) |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| tx_go | output | 1 | Permission to start the next character |

## Verification
A wrong hysteresis entry or a wrong clamp moves a mark. That error becomes visible on the request pin one clock after the count crosses the wrong value, so the vector walk steps each count one unit on either side of each mark. A pause state that is not held or not cleared shows up as the pin changing while the count sits between the marks, or as a stale high level when automatic control is re-enabled. A synchronizer of the wrong depth or reset value shifts the edge on `tx_go` by one clock, which is measured both at reset release and on a pin toggle.

// File: rtl/uart_afc_pkg.sv
// Shared constants and the hysteresis lookup for the flow control block.
// Assumes FIFO count widths of at least 6 bits, so every table entry fits.
package uart_afc_pkg;

    localparam int          HYST_W   = 4;
    localparam int          HCHAR_W  = 6;
    localparam logic [1:0]  TBL_HYST = 2'b11;

    typedef logic [HYST_W-1:0]  hyst_code_t;
    typedef logic [HCHAR_W-1:0] hyst_chars_t;

    // Maps the 4-bit hysteresis code to a character count (R1); this mapping is non-linear.
    function automatic hyst_chars_t hyst_chars(input hyst_code_t code);
        case (code)
            4'd0:  return 6'd0;
            4'd1:  return 6'd4;
            4'd2:  return 6'd6;
            4'd3:  return 6'd8;
            4'd4:  return 6'd8;
            4'd5:  return 6'd16;
            4'd6:  return 6'd24;
            4'd7:  return 6'd32;
            4'd8:  return 6'd40;
            4'd9:  return 6'd44;
            4'd10: return 6'd48;
            4'd11: return 6'd52;
            4'd12: return 6'd12;
            4'd13: return 6'd20;
            4'd14: return 6'd28;
            default: return 6'd36;
        endcase
    endfunction

endpackage

// File: rtl/uart_afc_thresh.sv
// Computes the pause (high) and resume (low) marks for the receive side.
// Purely combinational. The marks are one bit wider than the count so that
// trigger + hysteresis cannot wrap. Assumes CNT_W >= 6.
module uart_afc_thresh
    import uart_afc_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [1:0]       tbl_sel,
    input  hyst_code_t       hyst_code,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic [CNT_W-1:0] next_trig,
    output logic [CNT_W:0]   hi_mark,
    output logic [CNT_W:0]   lo_mark
);
    localparam int MW = CNT_W + 1;

    logic          use_hyst;
    logic [MW-1:0] trig_x;
    logic [MW-1:0] hyst_x;

    // Choose between the hysteresis band and the next-trigger-level fallback (R2, R3, R5).
    always_comb begin
        use_hyst = (tbl_sel == TBL_HYST) && (hyst_code != '0);
        trig_x   = {1'b0, rx_trig};
        hyst_x   = MW'(hyst_chars(hyst_code));
        if (use_hyst) begin
            hi_mark = trig_x + hyst_x;
            lo_mark = (trig_x > hyst_x) ? (trig_x - hyst_x) : '0;
        end else begin
            hi_mark = {1'b0, next_trig};
            lo_mark = (rx_trig == '0) ? '0 : (trig_x - MW'(1));
        end
    end

endmodule

// File: rtl/uart_afc_rts_gate.sv
// Holds the receive-side pause state. Sets it when the count reaches the high
// mark, clears it at or below the low mark, and holds it in between. Pause
// has priority over resume. Disabling automatic control clears the state.
module uart_afc_rts_gate #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W:0]   hi_mark,
    input  logic [CNT_W:0]   lo_mark,
    output logic             paused
);
    logic [CNT_W:0] cnt_x;
    logic           at_hi;
    logic           at_lo;

    // Compare the widened count against both marks.
    always_comb begin
        cnt_x = {1'b0, count};
        at_hi = cnt_x >= hi_mark;
        at_lo = cnt_x <= lo_mark;
    end

    // Pause state register with hold band and pause-first priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       paused <= 1'b0;
        else if (!enable) paused <= 1'b0;
        else if (at_hi)   paused <= 1'b1;
        else if (at_lo)   paused <= 1'b0;
    end

    p_pause_at_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && at_hi) |=> paused);
    p_resume_at_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && at_lo && !at_hi) |=> !paused);
    p_hold_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !at_lo && !at_hi) |=> (paused == $past(paused)));
    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !paused);

endmodule

// File: rtl/uart_afc_cts_sync.sv
// Two-flop synchronizer for the monitored active-low clear input. Both
// flops reset to 1 (deasserted), so transmission is held off until a
// real low level has passed through.
module uart_afc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;
    logic [1:0]        cyc;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], raw_n};
    end

    assign sync_n = chain[STAGES-1];

    // Count edges since reset (saturating) to qualify the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= 2'd0;
        else if (cyc != 2'd2) cyc <= cyc + 2'd1;
    end

    p_sync_reset_r9: assert property (@(posedge clk)
        !rst_n |=> sync_n);
    p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (sync_n == $past(raw_n, 2)));

endmodule

// File: rtl/uart_autoflow.sv
// Top level of automatic modem-line flow control for one UART channel.
// Chooses the RTS/CTS or DTR/DSR pin pair, drives the request output from
// the pause state or the software bit, and gates the transmit start permission
// with the synchronized clear input. Assumes all inputs except the modem
// pins are synchronous to clk.
module uart_autoflow
    import uart_afc_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic [CNT_W-1:0] next_trig,
    input  logic [1:0]       tbl_sel,
    input  logic [3:0]       hyst_code,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             pin_sel,
    input  logic             sw_rts,
    input  logic             sw_dtr,
    input  logic             cts_n,
    input  logic             dsr_n,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             tx_go
);
    logic [CNT_W:0] hi_mark;
    logic [CNT_W:0] lo_mark;
    logic           paused;
    logic           mon_raw_n;
    logic           mon_sync_n;
    logic           req_auto_n;

    uart_afc_thresh #(.CNT_W(CNT_W)) u_thresh (
        .tbl_sel   (tbl_sel),
        .hyst_code (hyst_code),
        .rx_trig   (rx_trig),
        .next_trig (next_trig),
        .hi_mark   (hi_mark),
        .lo_mark   (lo_mark)
    );

    uart_afc_rts_gate #(.CNT_W(CNT_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (auto_rts_en),
        .count   (rx_count),
        .hi_mark (hi_mark),
        .lo_mark (lo_mark),
        .paused  (paused)
    );

    // Select the monitored modem input (R7).
    assign mon_raw_n = pin_sel ? dsr_n : cts_n;

    uart_afc_cts_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (mon_raw_n),
        .sync_n (mon_sync_n)
    );

    // Drive the selected request pin from the pause state or its software bit (R6, R7).
    always_comb begin
        req_auto_n = auto_rts_en ? paused : 1'b0;
        if (pin_sel) begin
            rts_n = ~sw_rts;
            dtr_n = auto_rts_en ? req_auto_n : ~sw_dtr;
        end else begin
            rts_n = auto_rts_en ? req_auto_n : ~sw_rts;
            dtr_n = ~sw_dtr;
        end
    end

    // Withhold start-of-character permission while the synchronized input is high (R8).
    assign tx_go = !(auto_cts_en && mon_sync_n);

    p_lo_not_above_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_mark <= {1'b0, rx_trig});
    p_go_when_cts_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |-> tx_go);
    p_pin_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel |-> (rts_n == !sw_rts));

endmodule

// File: tb/tb_uart_autoflow.sv
// Self-checking bench: a vector walk over the marks, then directed tests.
module tb_uart_autoflow;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] rx_count, rx_trig, next_trig;
    logic [1:0]    tbl_sel;
    logic [3:0]    hyst_code;
    logic          auto_rts_en, auto_cts_en, pin_sel, sw_rts, sw_dtr, cts_n, dsr_n;
    logic          rts_n, dtr_n, tx_go;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_autoflow #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_trig(rx_trig),
        .next_trig(next_trig), .tbl_sel(tbl_sel), .hyst_code(hyst_code),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .pin_sel(pin_sel),
        .sw_rts(sw_rts), .sw_dtr(sw_dtr), .cts_n(cts_n), .dsr_n(dsr_n),
        .rts_n(rts_n), .dtr_n(dtr_n), .tx_go(tx_go)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Vector fields {req 4, tbl_sel 2, code 4, trig 7, next 7, count 7, exp rts_n 1}.
    // Applied in order; the pause state carries over from one entry to the next.
    localparam int NV = 31;
    localparam logic [31:0] VEC [NV] = '{
        // code 5 -> 16, trig 16: marks 32 / 0 (R1, R2, R3, R4)
        {4'd4, 2'b11, 4'd5,  7'd16, 7'd32, 7'd10, 1'b0},
        {4'd4, 2'b11, 4'd5,  7'd16, 7'd32, 7'd31, 1'b0},
        {4'd2, 2'b11, 4'd5,  7'd16, 7'd32, 7'd32, 1'b1},
        {4'd4, 2'b11, 4'd5,  7'd16, 7'd32, 7'd5,  1'b1},
        {4'd3, 2'b11, 4'd5,  7'd16, 7'd32, 7'd0,  1'b0},
        // code 8 -> 40, trig 8: marks 48 / 0 clamped (R1, R3)
        {4'd1, 2'b11, 4'd8,  7'd8,  7'd16, 7'd47, 1'b0},
        {4'd1, 2'b11, 4'd8,  7'd8,  7'd16, 7'd48, 1'b1},
        {4'd3, 2'b11, 4'd8,  7'd8,  7'd16, 7'd1,  1'b1},
        {4'd3, 2'b11, 4'd8,  7'd8,  7'd16, 7'd0,  1'b0},
        // code 12 -> 12, trig 32: marks 44 / 20 (R1, R2, R3)
        {4'd1, 2'b11, 4'd12, 7'd32, 7'd48, 7'd43, 1'b0},
        {4'd2, 2'b11, 4'd12, 7'd32, 7'd48, 7'd44, 1'b1},
        {4'd4, 2'b11, 4'd12, 7'd32, 7'd48, 7'd21, 1'b1},
        {4'd3, 2'b11, 4'd12, 7'd32, 7'd48, 7'd20, 1'b0},
        // code 1 -> 4, trig 8: marks 12 / 4 (R1)
        {4'd1, 2'b11, 4'd1,  7'd8,  7'd16, 7'd12, 1'b1},
        {4'd1, 2'b11, 4'd1,  7'd8,  7'd16, 7'd5,  1'b1},
        {4'd1, 2'b11, 4'd1,  7'd8,  7'd16, 7'd4,  1'b0},
        // code 15 -> 36, trig 20: marks 56 / 0 clamped (R1, R3)
        {4'd1, 2'b11, 4'd15, 7'd20, 7'd32, 7'd55, 1'b0},
        {4'd1, 2'b11, 4'd15, 7'd20, 7'd32, 7'd56, 1'b1},
        {4'd3, 2'b11, 4'd15, 7'd20, 7'd32, 7'd1,  1'b1},
        {4'd3, 2'b11, 4'd15, 7'd20, 7'd32, 7'd0,  1'b0},
        // code 6 -> 24, trig 24: marks 48 / 0 (R1)
        {4'd1, 2'b11, 4'd6,  7'd24, 7'd32, 7'd47, 1'b0},
        {4'd1, 2'b11, 4'd6,  7'd24, 7'd32, 7'd48, 1'b1},
        {4'd1, 2'b11, 4'd6,  7'd24, 7'd32, 7'd0,  1'b0},
        // other table, code ignored: marks next 32 / below trig 16 (R5)
        {4'd5, 2'b01, 4'd5,  7'd16, 7'd32, 7'd31, 1'b0},
        {4'd5, 2'b01, 4'd5,  7'd16, 7'd32, 7'd32, 1'b1},
        {4'd5, 2'b01, 4'd5,  7'd16, 7'd32, 7'd16, 1'b1},
        {4'd5, 2'b01, 4'd5,  7'd16, 7'd32, 7'd15, 1'b0},
        // table 3 with code 0 falls back: marks 16 / 7 (R5)
        {4'd5, 2'b11, 4'd0,  7'd8,  7'd16, 7'd16, 1'b1},
        {4'd5, 2'b11, 4'd0,  7'd8,  7'd16, 7'd7,  1'b0},
        // crossed marks, pause 10 / resume 19: pause wins (R10)
        {4'd10, 2'b01, 4'd0, 7'd20, 7'd10, 7'd15, 1'b1},
        {4'd10, 2'b01, 4'd0, 7'd20, 7'd10, 7'd0,  1'b0}
    };

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_count = '0; rx_trig = 7'd16; next_trig = 7'd32;
        tbl_sel = 2'b00; hyst_code = 4'd0; auto_rts_en = 1'b0; auto_cts_en = 1'b1;
        pin_sel = 1'b0; sw_rts = 1'b0; sw_dtr = 1'b1; cts_n = 1'b0; dsr_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset values of the pins and the synchronizer
        chk("R9 rts_n in reset", rts_n, 1'b1);
        chk("R7 dtr_n in reset", dtr_n, 1'b0);
        chk("R9 tx_go in reset", tx_go, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 tx_go 1 edge after reset", tx_go, 1'b0);
        @(negedge clk);
        chk("R8 tx_go 2 edges after reset", tx_go, 1'b1);

        // R8: a pin toggle takes two edges to reach tx_go
        cts_n = 1'b1;
        @(negedge clk);
        chk("R8 cts high, 1 edge", tx_go, 1'b1);
        @(negedge clk);
        chk("R8 cts high, 2 edges", tx_go, 1'b0);
        auto_cts_en = 1'b0; #1;
        chk("R8 gating disabled", tx_go, 1'b1);
        // R7: dsr_n is ignored while RTS/CTS is selected
        auto_cts_en = 1'b1; cts_n = 1'b0; dsr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 dsr ignored", tx_go, 1'b1);
        dsr_n = 1'b0;

        // Vector walk with automatic request control enabled
        auto_rts_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {tbl_sel, hyst_code, rx_trig, next_trig, rx_count} = VEC[i][27:1];
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", VEC[i][31:28], i), rts_n, VEC[i][0]);
        end

        // R6: software control, and the pause state is cleared on re-enable
        tbl_sel = 2'b11; hyst_code = 4'd5; rx_trig = 7'd16; rx_count = 7'd60;
        @(negedge clk);
        chk("R2 paused before disable", rts_n, 1'b1);
        auto_rts_en = 1'b0; sw_rts = 1'b1; #1;
        chk("R6 sw_rts=1", rts_n, 1'b0);
        sw_rts = 1'b0; #1;
        chk("R6 sw_rts=0", rts_n, 1'b1);
        rx_count = 7'd20;
        @(negedge clk);
        auto_rts_en = 1'b1; #1;
        chk("R6 cleared on re-enable", rts_n, 1'b0);

        // R7: DTR/DSR pair selected
        pin_sel = 1'b1; sw_rts = 1'b1; sw_dtr = 1'b0; rx_count = 7'd60;
        cts_n = 1'b0; dsr_n = 1'b1;
        @(negedge clk);
        chk("R7 dtr_n driven by pause", dtr_n, 1'b1);
        chk("R7 rts_n follows sw_rts", rts_n, 1'b0);
        @(negedge clk);
        chk("R7 dsr monitored", tx_go, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule